// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block watches the digital protection flags of an H-bridge motor stage and turns them into status bits, a pull-low request for an open-drain fault pin, and a bridge-off command. It handles four fault classes, and each behaves differently. A long current-limit episode is only reported, and the bridge keeps driving. A confirmed overcurrent on any power switch shuts the bridge off and keeps it off until software clears it. Over-temperature and undervoltage shut the bridge off only while the flag is present, and the bridge recovers without help.

Two persistence qualifiers filter the timed classes. Each is a small state machine with the states `QL_IDLE` (condition absent), `QL_COUNT` (condition present, counting) and `QL_HIT` (condition has persisted long enough). The transitions are: IDLE→COUNT when the condition appears; COUNT→COUNT while the condition holds below the limit; COUNT→HIT (or IDLE→HIT for a limit of one) when the count reaches the limit; any state→IDLE when the condition drops. The bridge state machine has the states `BR_RUN` (bridge enabled), `BR_HOLD` (disabled while over-temperature or undervoltage is live) and `BR_LOCK` (latched off by overcurrent). Its transitions are: any state→LOCK on a qualified overcurrent; LOCK→LOCK until a clear request arrives; otherwise →HOLD while over-temperature or undervoltage is live, and →RUN when neither is live.

Status bits are sticky. A live cause sets a bit, and that set takes priority over a clear request on the same edge. The summary bit and the pull-low request are the OR of the four cause bits.

Top module: `fault_supervisor`

## Requirements
- R1: When `ilim_cmp` is high with the bridge not coasting for ILIM_CYC consecutive clock edges, `flt_status[0]` (current-limit bit) reads 1 after the next edge, and `bridge_off` stays 0 because of it.
- R2: If `ilim_cmp` or the OR of `sw_oc` drops for even one edge before its limit is reached, that qualifier restarts from zero, and the bit does not set.
- R3: Coast (`drv_a`=0 and `drv_b`=0) clears `flt_status[0]` on the next edge and stops current-limit qualification. A one-cycle `clear_req` with the condition gone also clears it.
- R4: A high flag on any bit of `sw_oc` that persists for OCP_CYC consecutive edges sets `flt_status[1]` (overcurrent bit) and `bridge_off` after the next edge.
- R5: The overcurrent shutdown stays latched until a `clear_req` arrives while overcurrent is no longer qualified. After that clear, `bridge_off` follows the live over-temperature and undervoltage flags.
- R6: `over_temp` high at an edge sets `flt_status[2]` and `bridge_off` after that edge. `bridge_off` returns to 0 one edge after the flag drops, while `flt_status[2]` stays 1 until a clear.
- R7: `under_volt` behaves as in R6, using `flt_status[3]`.
- R8: `flt_status[4]` (summary) and `flt_pull_low` are 1 exactly when any of `flt_status[3:0]` is 1.
- R9: After reset all status bits, `flt_pull_low` and `bridge_off` are 0.
- R10: A clear request has no effect on a status bit whose cause is present at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilim_cmp | input | 1 | Current-limit comparator output |
| sw_oc | input | NUM_SW | Per-switch overcurrent flags |
| over_temp | input | 1 | Over-temperature flag |
| under_volt | input | 1 | Supply undervoltage flag |
| drv_a | input | 1 | Bridge direction bit A |
| drv_b | input | 1 | Bridge direction bit B |
| clear_req | input | 1 | One-cycle request to clear status |
| flt_status | output | 5 | [0] current limit, [1] overcurrent, [2] over-temperature, [3] undervoltage, [4] summary |
| flt_pull_low | output | 1 | Enable for the open-drain fault pin (1 = pull low) |
| bridge_off | output | 1 | Disable all bridge switches |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady between edges. They also assume that `clear_req` is a level sampled at each edge rather than an edge-detected pulse. The stimulus changes inputs only on falling clock edges. It drives `clear_req` high for exactly one cycle in directed cases. In the randomized run, the flags are held in long runs so that both timed qualifiers reach their limits and are also interrupted just short of them.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    typedef enum logic [1:0] {
        QL_IDLE  = 2'd0,
        QL_COUNT = 2'd1,
        QL_HIT   = 2'd2
    } qual_state_e;

    typedef enum logic [1:0] {
        BR_RUN  = 2'd0,
        BR_HOLD = 2'd1,
        BR_LOCK = 2'd2
    } bridge_state_e;

    localparam int unsigned CAUSE_W = 4;
    localparam int unsigned IDX_ILIM = 0;
    localparam int unsigned IDX_OCP  = 1;
    localparam int unsigned IDX_OT   = 2;
    localparam int unsigned IDX_UV   = 3;
endpackage

// File: rtl/fsup_persist.sv
module fsup_persist
    import fsup_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW:0] LIM_V = (CW + 1)'(LIMIT);

    qual_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (CW + 1)'(1);
        st_d    = st_q;
        cnt_d   = cnt_q;
        unique case (st_q)
            QL_IDLE, QL_COUNT: begin
                if (!cond) begin
                    st_d  = QL_IDLE;
                    cnt_d = '0;
                end else if (cnt_inc >= LIM_V) begin
                    st_d  = QL_HIT;
                    cnt_d = '0;
                end else begin
                    st_d  = QL_COUNT;
                    cnt_d = cnt_inc[CW-1:0];
                end
            end
            QL_HIT: begin
                if (!cond) st_d = QL_IDLE;
            end
            default: begin
                st_d  = QL_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= QL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        hit = (st_q == QL_HIT);
    end

    // R2: a dropped condition always returns the qualifier to its start
    p_drop_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (!hit && cnt_q == '0));

    // R2: a hit is only ever seen right after the condition was sampled high
    p_hit_needs_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(cond));
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[b] <= 1'b0;
            else if (set_i[b])  q[b] <= 1'b1;
            else if (clr_i[b])  q[b] <= 1'b0;
        end

        // R10: a cause present at an edge wins over a clear at the same edge
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> q[b]);
    end
endmodule

// File: rtl/fsup_bridge.sv
module fsup_bridge
    import fsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ocp_hit,
    input  logic auto_trip,
    input  logic clear_req,
    output logic bridge_off
);
    bridge_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BR_RUN, BR_HOLD: begin
                if (ocp_hit)        st_d = BR_LOCK;
                else if (auto_trip) st_d = BR_HOLD;
                else                st_d = BR_RUN;
            end
            BR_LOCK: begin
                if (ocp_hit || !clear_req) st_d = BR_LOCK;
                else if (auto_trip)        st_d = BR_HOLD;
                else                       st_d = BR_RUN;
            end
            default: st_d = BR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BR_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        bridge_off = (st_q != BR_RUN);
    end

    // R5: once locked, only a clear request can release the bridge
    p_lock_needs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BR_LOCK && !clear_req) |=> (st_q == BR_LOCK));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned NUM_SW   = 4,
    parameter int unsigned ILIM_CYC = 13_750_000,
    parameter int unsigned OCP_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ilim_cmp,
    input  logic [NUM_SW-1:0] sw_oc,
    input  logic              over_temp,
    input  logic              under_volt,
    input  logic              drv_a,
    input  logic              drv_b,
    input  logic              clear_req,
    output logic [4:0]        flt_status,
    output logic              flt_pull_low,
    output logic              bridge_off
);
    logic               coast;
    logic               ilim_live, ocp_live;
    logic               ilim_hit, ocp_hit;
    logic [CAUSE_W-1:0] cause_set, cause_clr, cause_q;

    always_comb begin
        coast     = !drv_a && !drv_b;
        ilim_live = ilim_cmp && !coast;
        ocp_live  = |sw_oc;
    end

    fsup_persist #(.LIMIT(ILIM_CYC)) u_ilim_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (ilim_live),
        .hit   (ilim_hit)
    );

    fsup_persist #(.LIMIT(OCP_CYC)) u_ocp_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (ocp_live),
        .hit   (ocp_hit)
    );

    always_comb begin
        cause_set           = '0;
        cause_set[IDX_ILIM] = ilim_hit && !coast;
        cause_set[IDX_OCP]  = ocp_hit;
        cause_set[IDX_OT]   = over_temp;
        cause_set[IDX_UV]   = under_volt;
        cause_clr           = {CAUSE_W{clear_req}};
        cause_clr[IDX_ILIM] = clear_req || coast;
    end

    fsup_latch #(.W(CAUSE_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cause_set),
        .clr_i (cause_clr),
        .q     (cause_q)
    );

    fsup_bridge u_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ocp_hit    (ocp_hit),
        .auto_trip  (over_temp || under_volt),
        .clear_req  (clear_req),
        .bridge_off (bridge_off)
    );

    always_comb begin
        flt_status   = {|cause_q, cause_q};
        flt_pull_low = |cause_q;
    end

    // R1: the bridge is only ever off with a shutdown-class cause recorded
    p_off_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_off |-> (flt_status[1] || flt_status[2] || flt_status[3]));

    // R3: coasting empties the current-limit bit on the next edge
    p_coast_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coast |=> !flt_status[0]);

    // R5: a latched overcurrent keeps the bridge off until a clear
    p_ocp_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_status[1] && !clear_req) |=> (flt_status[1] && bridge_off));

    // R6: over-temperature shuts the bridge down on the next edge
    p_ot_shuts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> (bridge_off && flt_status[2]));

    // R7: undervoltage shuts the bridge down on the next edge
    p_uv_shuts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        under_volt |=> (bridge_off && flt_status[3]));

    // R8: a newly raised current-limit bit always pulls the fault pin
    p_pin_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_status[0]) |-> (flt_pull_low && flt_status[4]));
endmodule

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
    localparam int NSW    = 4;
    localparam int ILIM_T = 40;
    localparam int OCP_T  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ilim_cmp = 1'b0;
    logic [NSW-1:0] sw_oc = '0;
    logic           over_temp = 1'b0;
    logic           under_volt = 1'b0;
    logic           drv_a = 1'b0;
    logic           drv_b = 1'b0;
    logic           clear_req = 1'b0;
    logic [4:0]     flt_status;
    logic           flt_pull_low;
    logic           bridge_off;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fault_supervisor #(.NUM_SW(NSW), .ILIM_CYC(ILIM_T), .OCP_CYC(OCP_T)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ilim_cmp     (ilim_cmp),
        .sw_oc        (sw_oc),
        .over_temp    (over_temp),
        .under_volt   (under_volt),
        .drv_a        (drv_a),
        .drv_b        (drv_b),
        .clear_req    (clear_req),
        .flt_status   (flt_status),
        .flt_pull_low (flt_pull_low),
        .bridge_off   (bridge_off)
    );

    // Behavioural reference: run lengths, sticky causes, bridge mode
    int       m_irun, m_orun;
    bit       m_iq, m_oq;
    bit [3:0] m_st;
    int       m_mode; // 0 running, 1 auto hold, 2 locked

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irun = 0; m_orun = 0; m_iq = 0; m_oq = 0; m_st = '0; m_mode = 0;
        end else begin
            bit coast, ilive, olive, niq, noq;
            bit [3:0] nst;
            int nmode;
            coast = !drv_a && !drv_b;
            ilive = ilim_cmp && !coast;
            olive = |sw_oc;
            m_irun = ilive ? m_irun + 1 : 0;
            m_orun = olive ? m_orun + 1 : 0;
            niq = (m_irun >= ILIM_T);
            noq = (m_orun >= OCP_T);
            nst[0] = (m_iq && !coast) || (m_st[0] && !(clear_req || coast));
            nst[1] = m_oq || (m_st[1] && !clear_req);
            nst[2] = over_temp || (m_st[2] && !clear_req);
            nst[3] = under_volt || (m_st[3] && !clear_req);
            if (m_oq || (m_mode == 2 && !clear_req)) nmode = 2;
            else if (over_temp || under_volt)        nmode = 1;
            else                                     nmode = 0;
            m_iq = niq; m_oq = noq; m_st = nst; m_mode = nmode;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R1 model ilim bit", 32'(flt_status[0]), 32'(m_st[0]));
            chk("R4 model ocp bit", 32'(flt_status[1]), 32'(m_st[1]));
            chk("R6 model ot bit", 32'(flt_status[2]), 32'(m_st[2]));
            chk("R7 model uv bit", 32'(flt_status[3]), 32'(m_st[3]));
            chk("R8 model summary", 32'(flt_status[4]), 32'(|m_st));
            chk("R8 model pull", 32'(flt_pull_low), 32'(|m_st));
            chk("R5 model bridge", 32'(bridge_off), 32'(m_mode != 0));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clear_req = 1'b1;
        step(1);
        clear_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;
        chk("R9 status after reset", 32'(flt_status), 32'h0);
        chk("R9 pull after reset", 32'(flt_pull_low), 32'h0);
        chk("R9 bridge after reset", 32'(bridge_off), 32'h0);

        // Current limit, interrupted then qualified
        drv_a = 1'b1;
        ilim_cmp = 1'b1; step(ILIM_T - 1);
        ilim_cmp = 1'b0; step(1);
        ilim_cmp = 1'b1; step(ILIM_T - 1);
        chk("R2 ilim interrupted", 32'(flt_status[0]), 32'h0);
        step(2);
        chk("R1 ilim qualified", 32'(flt_status[0]), 32'h1);
        chk("R1 bridge keeps running", 32'(bridge_off), 32'h0);
        chk("R8 pull on ilim", 32'(flt_pull_low), 32'h1);
        pulse_clear();
        chk("R10 clear while ilim live", 32'(flt_status[0]), 32'h1);
        ilim_cmp = 1'b0; step(2);
        pulse_clear();
        chk("R3 clear removes ilim", 32'(flt_status[0]), 32'h0);
        ilim_cmp = 1'b1; step(ILIM_T + 1);
        chk("R1 ilim qualified again", 32'(flt_status[0]), 32'h1);
        drv_a = 1'b0; step(1);
        chk("R3 coast removes ilim", 32'(flt_status[0]), 32'h0);
        step(ILIM_T + 3);
        chk("R3 no qualify in coast", 32'(flt_status[0]), 32'h0);
        ilim_cmp = 1'b0; drv_a = 1'b1; step(2);

        // Overcurrent
        sw_oc = 4'b0100; step(OCP_T - 1);
        sw_oc = 4'b0000; step(1);
        chk("R2 ocp interrupted", 32'(flt_status[1]), 32'h0);
        sw_oc = 4'b1000; step(OCP_T + 1);
        chk("R4 ocp bit", 32'(flt_status[1]), 32'h1);
        chk("R4 ocp bridge off", 32'(bridge_off), 32'h1);
        sw_oc = 4'b0000; step(5);
        chk("R5 lock holds", 32'(bridge_off), 32'h1);
        sw_oc = 4'b0001; step(OCP_T + 1);
        pulse_clear();
        chk("R5 clear during ocp", 32'(bridge_off), 32'h1);
        chk("R10 ocp bit kept", 32'(flt_status[1]), 32'h1);
        sw_oc = 4'b0000; step(2);
        pulse_clear();
        chk("R5 clear releases", 32'(bridge_off), 32'h0);
        chk("R5 ocp bit cleared", 32'(flt_status[1]), 32'h0);

        // Over-temperature
        over_temp = 1'b1; step(1);
        chk("R6 ot bridge off", 32'(bridge_off), 32'h1);
        chk("R6 ot bit", 32'(flt_status[2]), 32'h1);
        over_temp = 1'b0; step(1);
        chk("R6 ot auto resume", 32'(bridge_off), 32'h0);
        chk("R6 ot bit sticky", 32'(flt_status[2]), 32'h1);
        pulse_clear();
        chk("R6 ot bit cleared", 32'(flt_status[2]), 32'h0);

        // Undervoltage
        under_volt = 1'b1; step(1);
        chk("R7 uv bridge off", 32'(bridge_off), 32'h1);
        chk("R7 uv bit", 32'(flt_status[3]), 32'h1);
        pulse_clear();
        chk("R10 clear while uv live", 32'(flt_status[3]), 32'h1);
        under_volt = 1'b0; step(1);
        chk("R7 uv auto resume", 32'(bridge_off), 32'h0);
        pulse_clear();
        chk("R7 uv bit cleared", 32'(flt_status[3]), 32'h0);

        // Locked overcurrent released into an undervoltage hold
        sw_oc = 4'b0010; step(OCP_T + 1);
        sw_oc = 4'b0000; under_volt = 1'b1; step(2);
        pulse_clear();
        chk("R5 released into hold", 32'(bridge_off), 32'h1);
        chk("R5 ocp bit after release", 32'(flt_status[1]), 32'h0);
        under_volt = 1'b0; step(1);
        chk("R5 hold ends", 32'(bridge_off), 32'h0);
        pulse_clear();
        chk("R8 summary clear", 32'(flt_status[4]), 32'h0);
        chk("R8 pull clear", 32'(flt_pull_low), 32'h0);

        // Randomized run against the reference model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 30) == 0) ilim_cmp = ~ilim_cmp;
            if ($urandom_range(0, 8) == 0)  sw_oc = ($urandom_range(0, 2) == 0) ? NSW'($urandom) : '0;
            if ($urandom_range(0, 40) == 0) over_temp = ~over_temp;
            if ($urandom_range(0, 40) == 0) under_volt = ~under_volt;
            if ($urandom_range(0, 60) == 0) begin
                drv_a = 1'($urandom);
                drv_b = 1'($urandom);
            end
            clear_req = ($urandom_range(0, 25) == 0);
            step(1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule